// File: doc/BRIEF.md
# Universal Serial Shift Unit

This block is a processor-attached serial engine for synchronous transfers over either a three-wire link (clock, data out, data in) or a two-wire open-drain bus (clock and a shared data line). Software reaches it through a small register port: a byte-wide shift register, a status register that holds the flags and the edge counter, and a control register. Software runs the byte-level protocol itself. The hardware shifts bits, counts clock edges and flags events.

The shift register takes in one bit on every rising edge of the serial clock. The data input is always the shared data/input pin. The register's top bit goes out through an output latch. The latch is open while the clock is low and closed while it is high, so outgoing data changes only on the edge opposite to sampling. A separate edge counter counts both clock edges. When it wraps it sets a completion flag, which can raise an interrupt. There are three clock sources: a software strobe bit, a timer compare pulse, or the external clock pin. In two-wire mode the block also detects a start condition and can stretch the bus clock low until software clears the flags.

Top module: `sshift_unit`

## Requirements
- R1: After reset, all three registers read 0x00, and `do_out`, `sck_out`, `sda_low`, `scl_low`, `irq_start` and `irq_done` are all 0.
- R2: The data register (address 0) is read and written directly. A second write replaces the first byte, because no receive buffer exists.
- R3: On each rising serial clock edge, the shift register moves one place toward its MSB and takes the synchronised level of `sdi_in` into bit 0. This holds in both wire modes.
- R4: The output bit follows the shift register MSB only while the serial clock is low. While the clock is high it holds its value, so a byte of n bits appears MSB first and changes only at falling edges.
- R5: Every clock edge advances the 4-bit counter in status bits 3:0. A write to the status register loads it. When an edge takes it from 15 to 0, the done flag (status bit 6) is set, so a byte takes 16 edges from a count of 0.
- R6: Status bits 7 (start) and 6 (done) are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R7: Control bits 4:3 select the clock source. 00 means a control write with bit 0 set toggles the clock. 01 means each `tmr_match` pulse toggles it. 10 means edges of `sck_in` are used. 11 means no clock. A strobe or timer pulse that does not match the selected source has no effect.
- R8: Control bit 5 selects the wire mode. With 0 (three-wire), the latch drives `do_out`, the internal clock drives `sck_out`, and `sda_low` and `scl_low` stay 0. With 1 (two-wire), `sda_low` is the inverse of the latch, `scl_low` follows an internal clock that is low, and `do_out` and `sck_out` stay 0.
- R9: In two-wire mode, a falling `sdi_in` while `sck_in` is high sets the start flag. This does not happen in three-wire mode or while `sck_in` is low.
- R10: In two-wire mode with hold enabled (control bit 1), `scl_low` is asserted while the start or done flag is set. It is released when both flags are cleared.
- R11: `irq_start` is the start flag gated by control bit 7. `irq_done` is the done flag gated by control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| sdi_in | input | 1 | Serial data input / two-wire data line level |
| sck_in | input | 1 | Serial clock pin level |
| tmr_match | input | 1 | Timer compare pulse used as a clock source |
| do_out | output | 1 | Three-wire data output |
| sck_out | output | 1 | Three-wire clock output |
| sda_low | output | 1 | Two-wire data pull-down enable |
| scl_low | output | 1 | Two-wire clock pull-down enable |
| irq_start | output | 1 | Start-condition interrupt |
| irq_done | output | 1 | Counter-wrap interrupt |

## Verification
The assertions assume that pin levels reach the block only through its own synchroniser. They also assume that a status write and a clock edge never fall in the same cycle, because in that cycle the load would take priority over the count step. The directed tasks always let a pin settle for four cycles before the next register access. They also keep status writes apart from strobes and timer pulses, so every edge that the counter properties see is unambiguous.

// File: rtl/sshift_pkg.sv
// Shared register layout and clock-source encoding for the serial shift unit.
// Assumes an 8-bit register port with three addressable registers.
package sshift_pkg;
    typedef enum logic [1:0] {
        SRC_STROBE = 2'b00,
        SRC_TIMER  = 2'b01,
        SRC_EXT    = 2'b10,
        SRC_OFF    = 2'b11
    } clk_src_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int STAT_START_BIT = 7;
    localparam int STAT_DONE_BIT  = 6;

    typedef struct packed {
        logic     start_ie;
        logic     done_ie;
        logic     two_wire;
        clk_src_e src;
        logic     spare;
        logic     hold_en;
        logic     strobe;
    } ctrl_t;
endpackage

// File: rtl/sshift_pin_sync.sv
// Multi-flop synchroniser for asynchronous pin levels, with the previous synced
// value exposed for edge detection. Assumes pins are quasi-static relative to clk.
module sshift_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] pipe [0:STAGES];

    // Shift pin levels through the synchroniser chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= pin_i;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign sync_o = pipe[STAGES-1];
    assign prev_o = pipe[STAGES];
endmodule

// File: rtl/sshift_edge_ctr.sv
// Clock-edge counter: advances once per serial edge, loads from software,
// and flags the step that wraps it back to zero. Load takes priority over a step.
module sshift_edge_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count serial edges or take a software preload.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (step_i) cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = step_i && !load_i && (cnt_o == CNT_MAX);
endmodule

// File: rtl/sshift_shifter.sv
// Data shift register with output latch. Samples din on rising-edge events,
// and the latch follows the MSB only while the serial clock level is low.
module sshift_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sample_i,
    input  logic              din_i,
    input  logic              lvl_low_i,
    output logic [DATA_W-1:0] sr_o,
    output logic              lat_o
);
    logic [DATA_W-1:0] sr_nxt;

    // Next shift-register value: software write wins over a sample.
    always_comb begin
        if (wr_i)          sr_nxt = wdata_i;
        else if (sample_i) sr_nxt = {sr_o[DATA_W-2:0], din_i};
        else               sr_nxt = sr_o;
    end

    // Hold shift data and the transparent-while-low output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_o  <= '0;
            lat_o <= 1'b0;
        end else begin
            sr_o <= sr_nxt;
            if (lvl_low_i) lat_o <= sr_nxt[DATA_W-1];
        end
    end
endmodule

// File: rtl/sshift_unit.sv
// Universal serial shift unit top: register port, clock-source selection,
// wire-mode pin routing, start detection, clock hold and interrupts.
// Assumes sck_in/sdi_in are asynchronous and pass the internal synchroniser.
module sshift_unit
    import sshift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sdi_in,
    input  logic              sck_in,
    input  logic              tmr_match,
    output logic              do_out,
    output logic              sck_out,
    output logic              sda_low,
    output logic              scl_low,
    output logic              irq_start,
    output logic              irq_done
);
    localparam int STAT_PAD = DATA_W - 2 - CNT_W;

    ctrl_t             ctrl_q, ctrl_wr;
    logic              sck_q, sck_q_nxt;
    logic              start_f, done_f;
    logic [1:0]        pin_sync, pin_prev;
    logic              sck_s, sck_p, sda_s, sda_p;
    logic              wr_data, wr_stat, wr_ctrl;
    logic              tog, ext_clk, int_clk, ev_rise, ev_fall, ev_any, lvl_low;
    logic              start_ev, wrap, hold, lat;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr;

    assign wr_data = reg_we && (reg_addr == ADDR_DATA);
    assign wr_stat = reg_we && (reg_addr == ADDR_STAT);
    assign wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    assign ctrl_wr = ctrl_t'(reg_wdata);

    sshift_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pin_i({sck_in, sdi_in}),
        .sync_o(pin_sync), .prev_o(pin_prev)
    );
    assign {sck_s, sda_s} = pin_sync;
    assign {sck_p, sda_p} = pin_prev;

    // Decide whether an internally generated clock toggle happens this cycle.
    always_comb begin
        tog = 1'b0;
        if (wr_ctrl && ctrl_wr.strobe && ctrl_wr.src == SRC_STROBE) tog = 1'b1;
        if (tmr_match && ctrl_q.src == SRC_TIMER)                    tog = 1'b1;
    end

    assign ext_clk   = (ctrl_q.src == SRC_EXT);
    assign int_clk   = (ctrl_q.src == SRC_STROBE) || (ctrl_q.src == SRC_TIMER);
    assign sck_q_nxt = tog ? ~sck_q : sck_q;
    assign ev_rise   = ext_clk ? (sck_s && !sck_p) : (tog && !sck_q);
    assign ev_fall   = ext_clk ? (!sck_s && sck_p) : (tog && sck_q);
    assign ev_any    = ev_rise || ev_fall;
    assign lvl_low   = ext_clk ? !sck_s : !sck_q_nxt;
    assign start_ev  = ctrl_q.two_wire && sda_p && !sda_s && sck_s;

    sshift_edge_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .step_i(ev_any), .load_i(wr_stat),
        .load_val_i(reg_wdata[CNT_W-1:0]), .cnt_o(cnt), .wrap_o(wrap)
    );

    sshift_shifter #(.DATA_W(DATA_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_data), .wdata_i(reg_wdata),
        .sample_i(ev_rise), .din_i(sda_s), .lvl_low_i(lvl_low),
        .sr_o(sr), .lat_o(lat)
    );

    // Control register and internal clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sck_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q        <= ctrl_wr;
                ctrl_q.strobe <= 1'b0;
            end
            sck_q <= sck_q_nxt;
        end
    end

    // Sticky flags: hardware set wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_f <= 1'b0;
            done_f  <= 1'b0;
        end else begin
            start_f <= start_ev || (start_f && !(wr_stat && reg_wdata[STAT_START_BIT]));
            done_f  <= wrap     || (done_f  && !(wr_stat && reg_wdata[STAT_DONE_BIT]));
        end
    end

    // Register read multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADDR_DATA: reg_rdata = sr;
            ADDR_STAT: reg_rdata = {start_f, done_f, {STAT_PAD{1'b0}}, cnt};
            ADDR_CTRL: reg_rdata = ctrl_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign hold      = ctrl_q.hold_en && (start_f || done_f);
    assign do_out    = !ctrl_q.two_wire && lat;
    assign sck_out   = !ctrl_q.two_wire && int_clk && sck_q;
    assign sda_low   = ctrl_q.two_wire && !lat;
    assign scl_low   = ctrl_q.two_wire && (hold || (int_clk && !sck_q));
    assign irq_start = start_f && ctrl_q.start_ie;
    assign irq_done  = done_f && ctrl_q.done_ie;
endmodule

// File: rtl/sshift_unit_chk.sv
// Property checker for the serial shift unit, bound into every instance.
// Assumes status writes and clock edges do not coincide in the checked cycles.
module sshift_unit_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_any,
    input logic             wr_stat,
    input logic [CNT_W-1:0] cnt,
    input logic             done_f,
    input logic             start_f,
    input logic             two_wire,
    input logic             hold_en,
    input logic             clr_done,
    input logic             do_out,
    input logic             sck_out,
    input logic             scl_low
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_any && !wr_stat) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_any && !wr_stat && cnt == TOP) |=> done_f);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_f && !clr_done) |=> done_f);

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_wire && $past(!two_wire) && sck_out && $past(sck_out)) |-> $stable(do_out));

    // R9
    no_start_3w_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!two_wire && !start_f) |=> !start_f);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (two_wire && hold_en && (done_f || start_f)) |-> scl_low);
endmodule

bind sshift_unit sshift_unit_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ev_any(ev_any), .wr_stat(wr_stat), .cnt(cnt),
    .done_f(done_f), .start_f(start_f), .two_wire(ctrl_q.two_wire),
    .hold_en(ctrl_q.hold_en),
    .clr_done(wr_stat && reg_wdata[sshift_pkg::STAT_DONE_BIT]),
    .do_out(do_out), .sck_out(sck_out), .scl_low(scl_low)
);

// File: tb/sshift_unit_tb_top.sv
// Directed bench for the serial shift unit: one task per scenario.
module sshift_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sdi_in = 1'b0, sck_in = 1'b0, tmr_match = 1'b0;
    logic       do_out, sck_out, sda_low, scl_low, irq_start, irq_done;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 0;

    always #5 clk = ~clk;

    sshift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sdi_in(sdi_in),
        .sck_in(sck_in), .tmr_match(tmr_match), .do_out(do_out),
        .sck_out(sck_out), .sda_low(sda_low), .scl_low(scl_low),
        .irq_start(irq_start), .irq_done(irq_done)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; sdi_in = 1'b0; sck_in = 1'b0; tmr_match = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_match = 1'b1;
        @(negedge clk); tmr_match = 1'b0;
        wait_cyc(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        reg_read(2'd0, v); check("R1 data", v, 8'h00);
        reg_read(2'd1, v); check("R1 status", v, 8'h00);
        reg_read(2'd2, v); check("R1 ctrl", v, 8'h00);
        check("R1 pins", {2'b0, do_out, sck_out, sda_low, scl_low, irq_start, irq_done}, 8'h00);
    endtask

    task automatic t_data();
        logic [7:0] v;
        do_reset();
        reg_write(2'd0, 8'hA5); reg_read(2'd0, v); check("R2 first byte", v, 8'hA5);
        reg_write(2'd0, 8'h3C); reg_read(2'd0, v); check("R2 overwrite", v, 8'h3C);
    endtask

    task automatic t_byte();
        logic [7:0] v;
        logic [7:0] tx = 8'hB4, rx = 8'h6D, exp_sr;
        do_reset();
        reg_write(2'd0, tx);
        check("R4 initial MSB", {7'b0, do_out}, {7'b0, tx[7]});
        for (int i = 0; i < 8; i++) begin
            sdi_in = rx[7-i];
            wait_cyc(4);
            reg_write(2'd2, 8'h01);
            check("R4 held at rising", {6'b0, sck_out, do_out}, {6'b0, 1'b1, tx[7-i]});
            reg_write(2'd2, 8'h01);
            exp_sr = (tx << (i + 1)) | 8'(rx >> (7 - i));
            check("R4 change at falling", {7'b0, do_out}, {7'b0, exp_sr[7]});
            if (i == 3) begin
                reg_read(2'd1, v); check("R5 mid count", v, 8'h08);
            end
        end
        reg_read(2'd0, v); check("R3 received byte", v, rx);
        reg_read(2'd1, v); check("R5 wrap sets done", v, 8'h40);
    endtask

    task automatic t_preload_w1c();
        logic [7:0] v;
        do_reset();
        reg_write(2'd1, 8'h0E);
        reg_write(2'd2, 8'h01);
        reg_read(2'd1, v); check("R5 preload step", v, 8'h0F);
        reg_write(2'd2, 8'h01);
        reg_read(2'd1, v); check("R5 short transfer", v, 8'h40);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v); check("R6 write zero keeps", v, 8'h40);
        reg_write(2'd1, 8'h40);
        reg_read(2'd1, v); check("R6 write one clears", v, 8'h00);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        do_reset();
        pulse_tmr();
        reg_read(2'd1, v); check("R7 timer ignored in strobe", v, 8'h00);
        reg_write(2'd2, 8'h08);
        pulse_tmr(); pulse_tmr(); pulse_tmr();
        reg_read(2'd1, v); check("R7 timer edges", v, 8'h03);
        check("R7 timer clock level", {7'b0, sck_out}, 8'h01);
        reg_write(2'd2, 8'h09);
        reg_read(2'd1, v); check("R7 strobe ignored in timer", v, 8'h03);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        do_reset();
        reg_write(2'd2, 8'h10);
        sdi_in = 1'b1; wait_cyc(4);
        sck_in = 1'b1; wait_cyc(4);
        reg_read(2'd1, v); check("R7 ext rising counted", v, 8'h01);
        reg_read(2'd0, v); check("R3 ext sample", v, 8'h01);
        sck_in = 1'b0; wait_cyc(4);
        reg_read(2'd1, v); check("R7 ext falling counted", v, 8'h02);
        check("R8 no clock out in ext", {7'b0, sck_out}, 8'h00);
    endtask

    task automatic t_two_wire();
        do_reset();
        reg_write(2'd2, 8'h20);
        check("R8 tw low clock, zero data", {5'b0, do_out, sda_low, scl_low}, 8'h03);
        reg_write(2'd0, 8'h80);
        check("R8 tw data released", {5'b0, do_out, sda_low, scl_low}, 8'h01);
        reg_write(2'd2, 8'h21);
        check("R8 tw clock released", {6'b0, sck_out, scl_low}, 8'h00);
    endtask

    task automatic start_seq(input logic scl_level);
        sck_in = scl_level; sdi_in = 1'b1; wait_cyc(4);
        sdi_in = 1'b0; wait_cyc(4);
    endtask

    task automatic t_start();
        logic [7:0] v;
        do_reset();
        reg_write(2'd2, 8'h18);
        start_seq(1'b1);
        reg_read(2'd1, v); check("R9 no start in three-wire", v, 8'h00);
        do_reset();
        reg_write(2'd2, 8'h38);
        start_seq(1'b0);
        reg_read(2'd1, v); check("R9 no start with SCL low", v, 8'h00);
        do_reset();
        reg_write(2'd2, 8'h38);
        start_seq(1'b1);
        reg_read(2'd1, v); check("R9 start detected", v, 8'h80);
    endtask

    task automatic t_hold();
        do_reset();
        reg_write(2'd2, 8'h3A);
        check("R10 idle no hold", {7'b0, scl_low}, 8'h00);
        start_seq(1'b1);
        check("R10 hold on start", {7'b0, scl_low}, 8'h01);
        reg_write(2'd1, 8'h80);
        check("R10 release on clear", {7'b0, scl_low}, 8'h00);
        do_reset();
        reg_write(2'd2, 8'h38);
        start_seq(1'b1);
        check("R10 no hold when disabled", {7'b0, scl_low}, 8'h00);
    endtask

    task automatic t_irq();
        do_reset();
        reg_write(2'd2, 8'h40);
        reg_write(2'd1, 8'h0F);
        reg_write(2'd2, 8'h41);
        check("R11 done irq", {6'b0, irq_start, irq_done}, 8'h01);
        reg_write(2'd1, 8'h40);
        check("R11 done irq cleared", {6'b0, irq_start, irq_done}, 8'h00);
        do_reset();
        reg_write(2'd2, 8'hB8);
        start_seq(1'b1);
        check("R11 start irq", {6'b0, irq_start, irq_done}, 8'h02);
    endtask

    initial begin
        t_reset();
        t_data();
        t_byte();
        t_preload_w1c();
        t_timer();
        t_ext();
        t_two_wire();
        t_start();
        t_hold();
        t_irq();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule